// File: doc/BRIEF.md
# Indirect-Addressed SCSI Controller Register Front End

This block is the host-facing register front end of a simple SCSI bus controller. The host sees only two byte-wide ports. A write to the address port picks one of sixteen internal registers, and a read of that port returns an auxiliary status byte. The value port reads or writes the picked register. After every write through the value port the pointer steps to the next register, so the host can program a run of neighbouring registers after a single address write.

Behind the ports sit a sixteen-entry register file, a 24-bit transfer count built from three count registers, and a command decoder. The decoder acts on three commands: reset, select-with-attention and transfer-info. A small byte buffer collects command bytes, and an interrupt-pending flag drives the interrupt output. The SCSI bus itself is not modelled. A per-ID target-present mask stands in for selection, and a single direction input stands in for the target's choice of the next data phase. The collected bytes are offered to the target side on a read port.

Register indices used below: control 0x2, count high/middle/low 0x8/0x9/0xA, destination ID 0xB, command status (CSR) 0xC, command 0xD, data 0xE. High, middle and low must be consecutive so that auto-increment fills them in order.

Top module: `scsiRegFront`

## Requirements
- R1: Only host byte offset 3 (address/status port) and offset 7 (value port) are decoded. A write at any other offset changes no state. A read at any other offset returns 0x00.
- R2: A write to the address port loads the register pointer with the low 4 bits of the byte. The upper bits are discarded.
- R3: A read of the address port returns the auxiliary status on hostRData in the cycle after the read. Bit 0 (data buffer ready) is always 1, bit 7 equals the pending interrupt, and bits 6:1 are 0.
- R4: A write to the value port stores the byte into the pointed register and then advances the pointer by one, wrapping from 0xF to 0x0.
- R5: A read of the value port returns the pointed register in the next cycle and leaves the pointer unchanged. When the pointer is at the CSR (0xC), the pending interrupt is cleared.
- R6: Writing the command register with low 7 bits 0x00 performs a reset command. Bit 7 is ignored. The CSR becomes 0x01, the interrupt is raised and any active transfer ends.
- R7: Command 0x06 (select-with-attention) raises the interrupt. If targetMask bit [destination ID register bits 2:0] is 1, the CSR becomes 0x8A (phase mismatch 0x88 with command phase 0x02). Otherwise the CSR becomes 0x42 (selection timeout).
- R8: Command 0x20 (transfer-info) takes the count {0x8,0x9,0xA}, clears the buffer index to zero and clears the interrupt. A transfer becomes active only if the count is non-zero.
- R9: While a transfer is active, each data-register write puts the byte into buffer slot [index] (only the first BUF_DEPTH bytes are kept) and increments the index. When the index reaches the count, the interrupt is raised, the transfer ends and the CSR becomes 0x18 if targetDataOut is 1 (data-out) or 0x19 if it is 0 (data-in). bufRdByte shows slot bufRdIdx combinationally.
- R10: A control-register write with bit 3 set clears the pending interrupt. With bit 3 clear, it leaves the interrupt unchanged.
- R11: A data-register write with no transfer active sets errFlag. The buffer, the index, the CSR and the interrupt are left unchanged. errFlag holds until reset.
- R12: After reset the pointer, all registers, the buffer, irqOut, errFlag and hostRData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWData | input | 8 | Host write byte |
| hostRData | output | 8 | Read byte, valid the cycle after hostRd |
| irqOut | output | 1 | Interrupt pending |
| errFlag | output | 1 | Sticky stray-data-write flag |
| targetMask | input | 8 | One bit per target ID that answers selection |
| targetDataOut | input | 1 | Next phase after transfer: 1 data-out, 0 data-in |
| bufRdIdx | input | BUF_AW | Buffer slot to show |
| bufRdByte | output | 8 | Buffer slot contents |

## Verification
Every state change made by a host access (pointer, registers, CSR, interrupt, error flag, buffer) lands on the clock edge that samples the strobe. irqOut, errFlag and bufRdByte can therefore be compared one edge after the access. Read data is registered and shows on hostRData only in the cycle after the read strobe, after which it returns to zero. The bench drives each access on a falling edge, holds it across exactly one rising edge, removes it on the next falling edge and samples all outputs there. A bench model, stepped per access, supplies the expected values.

// File: rtl/scsiRegPkg.sv
package scsiRegPkg;
  localparam int NUM_REGS  = 16;
  localparam int REG_AW    = $clog2(NUM_REGS);
  localparam int BYTE_W    = 8;
  localparam int CNT_BYTES = 3;
  localparam int CNT_W     = CNT_BYTES * BYTE_W;

  // register indices; count bytes must stay consecutive for auto-increment
  localparam logic [REG_AW-1:0] REG_CTRL    = 4'h2;
  localparam logic [REG_AW-1:0] REG_CNT_HI  = 4'h8;
  localparam logic [REG_AW-1:0] REG_CNT_MID = 4'h9;
  localparam logic [REG_AW-1:0] REG_CNT_LO  = 4'hA;
  localparam logic [REG_AW-1:0] REG_DEST    = 4'hB;
  localparam logic [REG_AW-1:0] REG_CSR     = 4'hC;
  localparam logic [REG_AW-1:0] REG_CMD     = 4'hD;
  localparam logic [REG_AW-1:0] REG_DATA    = 4'hE;

  localparam logic [6:0] OP_RESET   = 7'h00;
  localparam logic [6:0] OP_SEL_ATN = 7'h06;
  localparam logic [6:0] OP_XFER    = 7'h20;

  localparam logic [7:0] ST_RESET_DONE  = 8'h01;
  localparam logic [7:0] ST_SEL_TIMEOUT = 8'h42;
  localparam logic [7:0] ST_MISMATCH    = 8'h88;
  localparam logic [7:0] ST_XFER_DONE   = 8'h18;
  localparam logic [7:0] PH_DATA_OUT    = 8'h00;
  localparam logic [7:0] PH_DATA_IN     = 8'h01;
  localparam logic [7:0] PH_CMD         = 8'h02;

  localparam int CTL_EDI_BIT = 3;

  typedef struct packed {
    logic       selLoad;
    logic       regWr;
    logic       rdAux;
    logic       rdVal;
    logic       csrLoad;
    logic [7:0] csrVal;
    logic       bufWr;
    logic       idxClear;
  } dpStrobe_t;
endpackage

// File: rtl/scsiRegDp.sv
module scsiRegDp
  import scsiRegPkg::*;
#(
  parameter int BUF_DEPTH = 16,
  localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [7:0]        wData,
  input  logic              irqPending,
  input  logic [BUF_AW-1:0] bufRdIdx,
  output logic [REG_AW-1:0] selPtr,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  bufIdx,
  output logic [2:0]        destIdLo,
  output logic [7:0]        rData,
  output logic [7:0]        bufRdByte
);
  logic [7:0] regFile [NUM_REGS];
  logic [7:0] bufMem  [BUF_DEPTH];
  logic       bufInRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (st.regWr)   regFile[selPtr]  <= wData;
      if (st.csrLoad) regFile[REG_CSR] <= st.csrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           selPtr <= '0;
    else if (st.selLoad) selPtr <= wData[REG_AW-1:0];
    else if (st.regWr)   selPtr <= REG_AW'(selPtr + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rData <= '0;
    else if (st.rdAux) rData <= {irqPending, 6'b0, 1'b1};
    else if (st.rdVal) rData <= regFile[selPtr];
    else               rData <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.idxClear) bufIdx <= '0;
    else if (st.bufWr)        bufIdx <= bufIdx + CNT_W'(1);
  end

  assign bufInRange = bufIdx < CNT_W'(BUF_DEPTH);

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) bufMem[g] <= '0;
      else if (st.bufWr && bufInRange && bufIdx[BUF_AW-1:0] == BUF_AW'(g))
        bufMem[g] <= wData;
    end
  end

  assign bufRdByte = bufMem[bufRdIdx];
  assign countVal  = {regFile[REG_CNT_HI], regFile[REG_CNT_MID], regFile[REG_CNT_LO]};
  assign destIdLo  = regFile[REG_DEST][2:0];

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.selLoad |=> selPtr == $past(wData[REG_AW-1:0]));
  // R4
  sel_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.regWr && !st.selLoad) |=> selPtr == REG_AW'($past(selPtr) + 1'b1));
  // R3
  aux_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rdAux |=> (rData[0] && rData[6:1] == 6'b0));
  // R6
  csr_single_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.csrLoad |-> !(st.regWr && selPtr == REG_CSR));
endmodule

// File: rtl/scsiRegCtl.sv
module scsiRegCtl
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [6:0]        opByte,
  input  logic [7:0]        targetMask,
  input  logic              targetDataOut,
  input  logic [REG_AW-1:0] selPtr,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  bufIdx,
  input  logic [2:0]        destIdLo,
  output dpStrobe_t         st,
  output logic              irqPending,
  output logic              errFlag
);
  logic addrHit, valHit, cmdWr, dataWr;
  logic irqSet, irqClr, errSet, actStart, actEnd, actNext;
  logic xferActive;

  assign addrHit = hostAddr == ADDR_W'(3);
  assign valHit  = hostAddr == ADDR_W'(7);

  always_comb begin
    st          = '0;
    st.selLoad  = hostWr && addrHit;
    st.regWr    = hostWr && valHit;
    st.rdAux    = hostRd && addrHit;
    st.rdVal    = hostRd && valHit;
    cmdWr       = st.regWr && selPtr == REG_CMD;
    dataWr      = st.regWr && selPtr == REG_DATA;
    irqSet      = 1'b0;
    irqClr      = 1'b0;
    errSet      = 1'b0;
    actStart    = 1'b0;
    actEnd      = 1'b0;
    actNext     = 1'b0;
    if (cmdWr) begin
      unique case (opByte)
        OP_RESET: begin
          st.csrLoad = 1'b1;
          st.csrVal  = ST_RESET_DONE;
          irqSet     = 1'b1;
          actEnd     = 1'b1;
        end
        OP_SEL_ATN: begin
          st.csrLoad = 1'b1;
          st.csrVal  = targetMask[destIdLo] ? (ST_MISMATCH | PH_CMD) : ST_SEL_TIMEOUT;
          irqSet     = 1'b1;
        end
        OP_XFER: begin
          st.idxClear = 1'b1;
          irqClr      = 1'b1;
          actStart    = 1'b1;
          actNext     = countVal != '0;
        end
        default: ;
      endcase
    end
    if (dataWr) begin
      if (xferActive) begin
        st.bufWr = 1'b1;
        if (bufIdx + CNT_W'(1) == countVal) begin
          actEnd     = 1'b1;
          irqSet     = 1'b1;
          st.csrLoad = 1'b1;
          st.csrVal  = ST_XFER_DONE | (targetDataOut ? PH_DATA_OUT : PH_DATA_IN);
        end
      end else begin
        errSet = 1'b1;
      end
    end
    if (st.regWr && selPtr == REG_CTRL && opByte[CTL_EDI_BIT]) irqClr = 1'b1;
    if (st.rdVal && selPtr == REG_CSR) irqClr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      errFlag    <= 1'b0;
      xferActive <= 1'b0;
    end else begin
      if (irqSet)      irqPending <= 1'b1;
      else if (irqClr) irqPending <= 1'b0;
      if (errSet)      errFlag <= 1'b1;
      if (actStart)    xferActive <= actNext;
      else if (actEnd) xferActive <= 1'b0;
    end
  end

  // R5
  csr_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdVal && selPtr == REG_CSR) |=> !irqPending);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && xferActive) |=> bufIdx == $past(bufIdx) + CNT_W'(1));
  // R9
  done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && xferActive && bufIdx + CNT_W'(1) == countVal) |=> (irqPending && !xferActive));
  // R11
  stray_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !xferActive) |=> $stable(bufIdx));
endmodule

// File: rtl/scsiRegFront.sv
module scsiRegFront
  import scsiRegPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BUF_DEPTH = 16,
  localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWData,
  output logic [7:0]        hostRData,
  output logic              irqOut,
  output logic              errFlag,
  input  logic [7:0]        targetMask,
  input  logic              targetDataOut,
  input  logic [BUF_AW-1:0] bufRdIdx,
  output logic [7:0]        bufRdByte
);
  dpStrobe_t         st;
  logic [REG_AW-1:0] selPtr;
  logic [CNT_W-1:0]  countVal, bufIdx;
  logic [2:0]        destIdLo;

  scsiRegCtl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .opByte(hostWData[6:0]), .targetMask(targetMask), .targetDataOut(targetDataOut),
    .selPtr(selPtr), .countVal(countVal), .bufIdx(bufIdx), .destIdLo(destIdLo),
    .st(st), .irqPending(irqOut), .errFlag(errFlag)
  );

  scsiRegDp #(.BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wData(hostWData), .irqPending(irqOut),
    .bufRdIdx(bufRdIdx), .selPtr(selPtr), .countVal(countVal), .bufIdx(bufIdx),
    .destIdLo(destIdLo), .rData(hostRData), .bufRdByte(bufRdByte)
  );
endmodule

// File: tb/scsiRegFront_tb.sv
module scsiRegFront_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic       irqOut, errFlag;
  logic [7:0] targetMask = '0;
  logic       targetDataOut = 1'b0;
  logic [3:0] bufRdIdx = '0;
  logic [7:0] bufRdByte;

  scsiRegFront u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWData(hostWData), .hostRData(hostRData), .irqOut(irqOut), .errFlag(errFlag),
    .targetMask(targetMask), .targetDataOut(targetDataOut),
    .bufRdIdx(bufRdIdx), .bufRdByte(bufRdByte)
  );

  int checks = 0, fails = 0;

  logic [7:0]  mReg [16];
  logic [7:0]  mBuf [16];
  logic [3:0]  mSel;
  logic        mIrq, mErr, mActive;
  logic [23:0] mIdx;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelClear();
    for (int i = 0; i < 16; i++) begin mReg[i] = '0; mBuf[i] = '0; end
    mSel = '0; mIrq = 1'b0; mErr = 1'b0; mActive = 1'b0; mIdx = '0;
  endfunction

  function automatic logic [23:0] mCount();
    return {mReg[8], mReg[9], mReg[10]};
  endfunction

  function automatic void modelWrVal(logic [7:0] b);
    logic [3:0] s = mSel;
    mReg[s] = b;
    if (s == 4'hD) begin
      case (b[6:0])
        7'h00: begin mReg[12] = 8'h01; mIrq = 1'b1; mActive = 1'b0; end
        7'h06: begin mIrq = 1'b1; mReg[12] = targetMask[mReg[11][2:0]] ? 8'h8A : 8'h42; end
        7'h20: begin mIdx = '0; mIrq = 1'b0; mActive = mCount() != 0; end
        default: ;
      endcase
    end else if (s == 4'hE) begin
      if (mActive) begin
        if (mIdx < 16) mBuf[mIdx[3:0]] = b;
        mIdx++;
        if (mIdx == mCount()) begin
          mActive = 1'b0; mIrq = 1'b1;
          mReg[12] = targetDataOut ? 8'h18 : 8'h19;
        end
      end else mErr = 1'b1;
    end else if (s == 4'h2 && b[3]) mIrq = 1'b0;
    mSel = s + 4'd1;
  endfunction

  task automatic access(logic [3:0] a, logic w, logic r, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWr = w; hostRd = r; hostWData = d;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  task automatic flags(string req);
    chk({req, " irq"}, irqOut, mIrq);
    chk({req, " err"}, errFlag, mErr);
  endtask

  task automatic wrAddr(logic [7:0] b, string req);
    access(4'd3, 1'b1, 1'b0, b);
    mSel = b[3:0];
    flags(req);
  endtask

  task automatic wrVal(logic [7:0] b, string req);
    access(4'd7, 1'b1, 1'b0, b);
    modelWrVal(b);
    flags(req);
  endtask

  task automatic rdVal(string req);
    logic [7:0] e = mReg[mSel];
    access(4'd7, 1'b0, 1'b1, 8'h00);
    chk({req, " value read"}, hostRData, e);
    if (mSel == 4'hC) mIrq = 1'b0;
    flags(req);
  endtask

  task automatic rdAux(string req);
    logic [7:0] e = {mIrq, 6'b0, 1'b1};
    access(4'd3, 1'b0, 1'b1, 8'h00);
    chk({req, " aux"}, hostRData, e);
  endtask

  task automatic setReg(logic [3:0] idx, logic [7:0] b, string req);
    wrAddr({4'h0, idx}, req);
    wrVal(b, req);
  endtask

  task automatic chkBuf(logic [3:0] idx, string req);
    bufRdIdx = idx;
    #1;
    chk({req, " buffer"}, bufRdByte, mBuf[idx]);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelClear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5C51);
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rdata", hostRData, 0);
    flags("R12");
    rdVal("R12");
    chkBuf(4'd5, "R12");
    rdAux("R3 idle");
    // R4 auto-increment through the count registers
    wrAddr(8'h08, "R2");
    wrVal(8'h00, "R4"); wrVal(8'h00, "R4"); wrVal(8'h03, "R4");
    wrAddr(8'h0A, "R2"); rdVal("R4 count low");
    rdVal("R5 pointer held");
    // R4 wrap, R2 mask
    wrAddr(8'h0F, "R2"); wrVal(8'h5A, "R4"); rdVal("R4 wrap to 0");
    wrAddr(8'h1F, "R2 mask"); rdVal("R2 masked select");
    // R1 other offsets
    wrAddr(8'h02, "R1");
    access(4'd11, 1'b1, 1'b0, 8'h0D); flags("R1");
    access(4'd0, 1'b1, 1'b0, 8'h0D);  flags("R1");
    rdVal("R1 pointer untouched");
    access(4'd4, 1'b0, 1'b1, 8'h00); chk("R1 other read", hostRData, 0);
    // R6 reset command with bit 7 set
    setReg(4'hD, 8'h80, "R6");
    rdAux("R6 irq in aux");
    wrAddr(8'h0C, "R5"); rdVal("R6 csr");
    rdAux("R5 irq cleared");
    // R7 selection
    targetMask = 8'h04;
    setReg(4'hB, 8'h02, "R7");
    setReg(4'hD, 8'h06, "R7 present");
    wrAddr(8'h0C, "R7"); rdVal("R7 mismatch csr");
    setReg(4'hB, 8'h03, "R7");
    setReg(4'hD, 8'h06, "R7 absent");
    wrAddr(8'h0C, "R7"); rdVal("R7 timeout csr");
    setReg(4'hD, 8'h06, "R7 irq");
    // R10 control write
    setReg(4'h2, 8'h00, "R10 bit3 clear keeps irq");
    setReg(4'h2, 8'h08, "R10 bit3 set clears irq");
    // R8/R9 three-byte transfer, data-out
    targetDataOut = 1'b1;
    setReg(4'hD, 8'h20, "R8 start");
    wrVal(8'hA1, "R9");
    setReg(4'hE, 8'hA2, "R9");
    setReg(4'hE, 8'hA3, "R9 done out");
    chkBuf(4'd0, "R9"); chkBuf(4'd1, "R9"); chkBuf(4'd2, "R9");
    wrAddr(8'h0C, "R9"); rdVal("R9 csr out");
    // R11 stray write
    setReg(4'hE, 8'h55, "R11 stray");
    chkBuf(4'd3, "R11 slot untouched");
    wrAddr(8'h0C, "R11"); rdVal("R11 csr kept");
    // two-byte transfer, data-in
    targetDataOut = 1'b0;
    setReg(4'hA, 8'h02, "R9");
    setReg(4'hD, 8'h20, "R8 start");
    wrVal(8'hB1, "R9");
    setReg(4'hE, 8'hB2, "R9 done in");
    wrAddr(8'h0C, "R9"); rdVal("R9 csr in");
    chkBuf(4'd1, "R9");
    // R8 zero count leaves no transfer active
    doReset();
    flags("R12 second reset");
    setReg(4'hD, 8'h20, "R8 zero count");
    wrVal(8'h77, "R8 zero count write is stray");
    chkBuf(4'd0, "R8");
    // constrained random
    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 9);
      case (k)
        0, 1: wrAddr(8'($urandom_range(0, 255)), "R2 rand");
        2, 3, 4: begin
          logic [7:0] d = 8'($urandom_range(0, 255));
          if (mSel == 4'h8 || mSel == 4'h9) d = 8'h00;
          if (mSel == 4'hA) d = 8'($urandom_range(0, 5));
          if (mSel == 4'hD) begin
            case ($urandom_range(0, 4))
              0: d = 8'h00; 1: d = 8'h06; 2: d = 8'h20; 3: d = 8'hA0; default: ;
            endcase
          end
          wrVal(d, "R9 rand");
        end
        5, 6: rdVal("R5 rand");
        7: rdAux("R3 rand");
        8: begin
          logic [3:0] a = 4'($urandom_range(0, 15));
          if (a == 4'd3 || a == 4'd7) a = 4'd9;
          access(a, 1'b1, 1'b0, 8'($urandom_range(0, 255)));
          flags("R1 rand");
        end
        default: begin
          targetMask = 8'($urandom_range(0, 255));
          targetDataOut = 1'($urandom_range(0, 1));
          chkBuf(4'($urandom_range(0, 15)), "R9 rand");
        end
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule